// File: doc/BRIEF.md
# Serial Transmitter with Idle Preamble

This block sends characters on an asynchronous serial line. Software places a character in a one-entry holding register. At the next bit-time boundary, the character moves into a shift register. From there it goes out as a framed character: a low start bit, then the data bits least significant first, then a high stop bit. A bit-rate enable pulse from outside the block sets the pace, and each transmitted bit lasts one pulse interval. A word-size select chooses between 8 data bits (10-bit frame) and 9 data bits (11-bit frame).

A transmit enable gates the line. While the enable is clear, the line is held high. Software can still fill the holding register, but nothing is moved into the shift register. Each time the enable goes from clear to set, the block queues a preamble: a run of high bits as long as one frame. The next character waits until the preamble has been sent. If a character is still shifting when the enable is cleared and set again, the preamble starts right after that character's stop bit. Software uses this to guarantee a minimum idle gap between messages.

A holding-empty flag and an interrupt output (the flag gated by an interrupt enable) tell software when to write the next character. Neither depends on the transmit enable.

Top module: `ser_tx`

## Requirements
- R1: While the transmit enable is clear, `txd` is 1.
- R2: A write to the holding register while the transmit enable is clear makes `hold_empty` 0 on the next clock. The character is not moved: `hold_empty` stays 0 and `txd` stays 1 for as long as the enable stays clear.
- R3: `tx_irq` equals `hold_empty` AND the interrupt enable, whatever the state of the transmit enable.
- R4: A 0-to-1 change of the transmit enable queues a preamble of high bits lasting 10 bit times (short word) or 11 bit times (long word). If the line is idle and a character is waiting, that character's start bit begins at the (length+1)-th bit-rate pulse after the enable write.
- R5: The frame is one 0 start bit, then the data bits LSB first, then one 1 stop bit. The data is `data_in[7:0]` when `cfg_long_word`=0, and `data_in[8:0]` when it is 1; `data_in[8]` has no effect in short mode. Each bit lasts one pulse interval.
- R6: If the enable is cleared and set again while a character is shifting, the preamble follows that character's stop bit. The next character's start bit then comes two frame lengths after the first character's start bit.
- R7: If the holding register is empty when the preamble ends, `txd` stays 1. A character written later starts at the first bit-rate pulse after the write.
- R8: `hold_empty` returns to 1 only on a bit-rate pulse, when the character moves to the shift register. A character written while another is shifting starts exactly one frame length after it.
- R9: Reset clears the transmit enable, interrupt enable, word-size select and any queued preamble, and leaves the holding register empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bit_tick | input | 1 | One-clock bit-rate enable pulse |
| data_we | input | 1 | Holding register write strobe |
| data_in | input | 9 | Character to send (bit 8 used in long mode only) |
| cfg_we | input | 1 | Control register write strobe |
| cfg_tx_en | input | 1 | Transmit enable value |
| cfg_long_word | input | 1 | Word size: 0 = 10-bit frame, 1 = 11-bit frame |
| cfg_irq_en | input | 1 | Transmit interrupt enable value |
| txd | output | 1 | Serial output, idle high |
| hold_empty | output | 1 | Holding register empty flag |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
`hold_empty` and `tx_irq` react one clock after a write strobe. The bench checks them at the following falling edge.

Line timing is counted in bit-rate pulses. The bench keeps its own pulse counter and writes control values one clock after a pulse, so that a write never shares an edge with a pulse. Each start bit appears half a clock after the pulse edge that loads it. The bench detects it at that point and compares the pulse count against length+1, the frame length, or twice the frame length.

Each frame bit is sampled four clocks into its eight-clock interval, away from both of its edges.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

    typedef struct packed {
        logic en;         // transmit enable
        logic long_word;  // 1: 9 data bits, 11-bit frame
        logic irq_en;     // transmit interrupt enable
        logic pend;       // idle preamble queued
    } ctl_t;

endpackage

// File: rtl/ser_tx_frame.sv
module ser_tx_frame #(
    parameter int DATA_W  = 8,
    parameter int FRAME_W = DATA_W + 3,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic [DATA_W:0]    data,
    input  logic               long_word,
    input  logic               preamble,
    output logic [FRAME_W-1:0] bits,
    output logic [CNT_W-1:0]   len
);

    always_comb begin
        if (preamble) begin
            bits = '1;
        end else if (long_word) begin
            bits = {1'b1, data, 1'b0};
        end else begin
            bits = {2'b11, data[DATA_W-1:0], 1'b0};
        end
        len = long_word ? CNT_W'(FRAME_W) : CNT_W'(FRAME_W - 1);
    end

endmodule

// File: rtl/ser_tx_hold.sv
module ser_tx_hold #(
    parameter int HOLD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [HOLD_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [HOLD_W-1:0] data
);

    typedef struct packed {
        logic              full;
        logic [HOLD_W-1:0] data;
    } hold_t;

    hold_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (take) begin
            s_d.full = 1'b0;
        end
        if (wr_en) begin
            s_d.full = 1'b1;
            s_d.data = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign full = s_q.full;
    assign data = s_q.data;

endmodule

// File: rtl/ser_tx_shifter.sv
module ser_tx_shifter #(
    parameter int FRAME_W = 11,
    parameter int CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_bits,
    input  logic [CNT_W-1:0]   load_len,
    output logic               boundary,
    output logic               bit_out
);

    typedef struct packed {
        logic [FRAME_W-1:0] sh;
        logic [CNT_W-1:0]   cnt;
    } shf_t;

    shf_t s_d, s_q;

    assign boundary = tick && (s_q.cnt <= CNT_W'(1));

    always_comb begin
        s_d = s_q;
        if (tick) begin
            if (s_q.cnt > CNT_W'(1)) begin
                s_d.sh  = {1'b1, s_q.sh[FRAME_W-1:1]};
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end else if (load) begin
                s_d.sh  = load_bits;
                s_d.cnt = load_len;
            end else begin
                s_d.sh  = '1;
                s_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.sh  <= '1;
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bit_out = (s_q.cnt == '0) ? 1'b1 : s_q.sh[0];

endmodule

// File: rtl/ser_tx.sv
module ser_tx #(
    parameter int DATA_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_tick,
    input  logic            data_we,
    input  logic [DATA_W:0] data_in,
    input  logic            cfg_we,
    input  logic            cfg_tx_en,
    input  logic            cfg_long_word,
    input  logic            cfg_irq_en,
    output logic            txd,
    output logic            hold_empty,
    output logic            tx_irq
);
    import ser_tx_pkg::*;

    localparam int HOLD_W  = DATA_W + 1;
    localparam int FRAME_W = DATA_W + 3;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    ctl_t ctl_d, ctl_q;

    logic               hold_full;
    logic [HOLD_W-1:0]  hold_data;
    logic               boundary;
    logic               bit_out;
    logic               load_pre;
    logic               take;
    logic               en_rise;
    logic [FRAME_W-1:0] frame_bits;
    logic [CNT_W-1:0]   frame_len;

    assign load_pre = boundary && ctl_q.en && ctl_q.pend;
    assign take     = boundary && ctl_q.en && !ctl_q.pend && hold_full;
    assign en_rise  = cfg_we && cfg_tx_en && !ctl_q.en;

    always_comb begin
        ctl_d = ctl_q;
        if (cfg_we) begin
            ctl_d.en        = cfg_tx_en;
            ctl_d.long_word = cfg_long_word;
            ctl_d.irq_en    = cfg_irq_en;
        end
        ctl_d.pend = ctl_d.en && (en_rise || (ctl_q.pend && !load_pre));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    ser_tx_hold #(.HOLD_W(HOLD_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (data_we),
        .wr_data (data_in),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    ser_tx_frame #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_frame (
        .data      (hold_data),
        .long_word (ctl_q.long_word),
        .preamble  (load_pre),
        .bits      (frame_bits),
        .len       (frame_len)
    );

    ser_tx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (bit_tick),
        .load      (load_pre || take),
        .load_bits (frame_bits),
        .load_len  (frame_len),
        .boundary  (boundary),
        .bit_out   (bit_out)
    );

    assign txd        = ctl_q.en ? bit_out : 1'b1;
    assign hold_empty = !hold_full;
    assign tx_irq     = hold_empty && ctl_q.irq_en;

endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic data_we,
    input logic txd,
    input logic hold_empty,
    input logic tx_irq,
    input logic en_q,
    input logic pend_q
);

    AST_LINE_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> txd); // R1

    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        data_we |=> !hold_empty); // R2

    AST_HELD_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !hold_empty) |=> !hold_empty); // R2

    AST_IRQ_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> hold_empty); // R3

    AST_RISE_QUEUES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_q) |-> pend_q); // R4

    AST_EMPTY_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_empty) |-> $past(bit_tick)); // R8

endmodule

bind ser_tx ser_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .data_we    (data_we),
    .txd        (txd),
    .hold_empty (hold_empty),
    .tx_irq     (tx_irq),
    .en_q       (ctl_q.en),
    .pend_q     (ctl_q.pend)
);

// File: tb/test_ser_tx.sv
`timescale 1ns/1ps
module test_ser_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       data_we = 1'b0;
    logic [8:0] data_in = '0;
    logic       cfg_we = 1'b0;
    logic       cfg_tx_en = 1'b0;
    logic       cfg_long_word = 1'b0;
    logic       cfg_irq_en = 1'b0;
    logic       txd, hold_empty, tx_irq;

    int checks = 0;
    int errors = 0;
    int nticks = 0;
    logic [2:0] tdiv = '0;

    always #2 clk = ~clk;

    ser_tx i_ser_tx (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
        .data_we(data_we), .data_in(data_in),
        .cfg_we(cfg_we), .cfg_tx_en(cfg_tx_en),
        .cfg_long_word(cfg_long_word), .cfg_irq_en(cfg_irq_en),
        .txd(txd), .hold_empty(hold_empty), .tx_irq(tx_irq)
    );

    // bit-rate pulse: one clock in eight
    always @(negedge clk) begin
        tdiv     <= tdiv + 3'd1;
        bit_tick <= (tdiv == 3'd7);
    end

    always @(posedge clk) begin
        if (bit_tick) nticks <= nticks + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic exp_bit(input logic [8:0] d, input bit lw, input int i);
        int nd = lw ? 9 : 8;
        if (i == 0) return 1'b0;
        if (i <= nd) return d[i-1];
        return 1'b1;
    endfunction

    function automatic int flen(input bit lw);
        return lw ? 11 : 10;
    endfunction

    task automatic wait_tick_sync();
        do @(posedge clk); while (!bit_tick);
        @(negedge clk);
    endtask

    task automatic cfg(input bit en, input bit lw, input bit ie);
        cfg_we = 1'b1; cfg_tx_en = en; cfg_long_word = lw; cfg_irq_en = ie;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr(input logic [8:0] d);
        data_we = 1'b1; data_in = d;
        @(negedge clk);
        data_we = 1'b0;
    endtask

    task automatic find_start(output int t);
        int n = 0;
        while (txd !== 1'b0 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        t = nticks;
        if (n >= 3000) check(1'b0, "start bit timeout", 1, 0);
    endtask

    task automatic check_frame(input logic [8:0] d, input bit lw, input string req);
        int bad = 0;
        for (int i = 0; i < flen(lw); i++) begin
            repeat ((i == 0) ? 4 : 8) @(negedge clk);
            if (txd !== exp_bit(d, lw, i)) bad++;
        end
        check(bad == 0, req, bad, 0);
    endtask

    task automatic wait_ticks(input int n);
        int t0 = nticks;
        while (nticks < t0 + n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int t0, t1, ts, bad;
        logic [8:0] d;
        bit lw;
        void'($urandom(32'h5EED1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check(txd == 1'b1, "R9 txd after reset", int'(txd), 1);
        check(hold_empty == 1'b1, "R9 empty after reset", int'(hold_empty), 1);
        check(tx_irq == 1'b0, "R9 irq after reset", int'(tx_irq), 0);

        // R3: interrupt follows empty flag with transmitter disabled
        cfg(1'b0, 1'b0, 1'b1);
        check(tx_irq == 1'b1, "R3 irq while disabled", int'(tx_irq), 1);
        wr(9'h0A5);
        check(hold_empty == 1'b0, "R2 flag clears while disabled", int'(hold_empty), 0);
        check(tx_irq == 1'b0, "R3 irq drops on write", int'(tx_irq), 0);
        // R1/R2: line idle, character held
        bad = 0;
        t0 = nticks;
        while (nticks < t0 + 30) begin
            @(negedge clk);
            if (txd !== 1'b1) bad++;
        end
        check(bad == 0, "R1 line high while disabled", bad, 0);
        check(hold_empty == 1'b0, "R2 character not moved", int'(hold_empty), 0);

        // R4: short preamble then waiting character
        wait_tick_sync();
        t0 = nticks;
        cfg(1'b1, 1'b0, 1'b1);
        find_start(t1);
        check(t1 - t0 == 11, "R4 short preamble length", t1 - t0, 11);
        check(hold_empty == 1'b1, "R8 flag sets on transfer", int'(hold_empty), 1);
        check_frame(9'h0A5, 1'b0, "R5 short frame");

        // R7: nothing waiting after preamble: line stays idle
        bad = 0;
        t0 = nticks;
        while (nticks < t0 + 20) begin
            @(negedge clk);
            if (txd !== 1'b1) bad++;
        end
        check(bad == 0, "R7 idle without data", bad, 0);
        wait_tick_sync();
        t0 = nticks;
        wr(9'h13C);
        find_start(t1);
        check(t1 - t0 == 1, "R7 start at first pulse after write", t1 - t0, 1);
        check_frame(9'h13C, 1'b0, "R5 short frame ignores bit 8");

        // R4: long preamble
        cfg(1'b0, 1'b1, 1'b1);
        wr(9'h1B3);
        wait_tick_sync();
        t0 = nticks;
        cfg(1'b1, 1'b1, 1'b1);
        find_start(t1);
        check(t1 - t0 == 12, "R4 long preamble length", t1 - t0, 12);
        check_frame(9'h1B3, 1'b1, "R5 long frame");

        // R8 back-to-back and R6 toggle, both word sizes
        for (int k = 0; k < 4; k++) begin
            lw = k[0];
            cfg(1'b1, lw, 1'b1);
            wait_ticks(2);
            wr(9'h0F0 + 9'(k));
            find_start(ts);
            d = 9'h10F ^ 9'(k * 37);
            wr(d);
            if (k >= 2) begin
                wait_tick_sync();
                cfg(1'b0, lw, 1'b1);
                cfg(1'b1, lw, 1'b1);
            end
            while (nticks < ts + flen(lw)) @(negedge clk);
            find_start(t1);
            if (k >= 2)
                check(t1 - ts == 2 * flen(lw), "R6 preamble after stop bit", t1 - ts, 2 * flen(lw));
            else
                check(t1 - ts == flen(lw), "R8 back-to-back spacing", t1 - ts, flen(lw));
            check_frame(d, lw, "R5 second frame");
        end

        // R5: random characters and word sizes
        for (int k = 0; k < 24; k++) begin
            lw = 1'($urandom);
            d = 9'($urandom);
            cfg(1'b1, lw, 1'b1);
            wr(d);
            find_start(t1);
            check_frame(d, lw, "R5 random frame");
        end

        // R9: reset clears the enable
        wait_ticks(12);
        cfg(1'b1, 1'b1, 1'b1);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_irq == 1'b0, "R9 irq enable cleared", int'(tx_irq), 0);
        wr(9'h055);
        bad = 0;
        t0 = nticks;
        while (nticks < t0 + 15) begin
            @(negedge clk);
            if (txd !== 1'b1) bad++;
        end
        check(bad == 0 && hold_empty == 1'b0, "R9 enable cleared by reset", bad, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule